// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network controller's descriptor-ring DMA engine. Software places a ring of 16-byte descriptors in memory. Each descriptor holds a buffer pointer, a negated buffer size, a status half-word carrying an ownership flag, and a message-length word. The block is given the ring base and the log2 of the entry count. When a frame begins on its byte stream, it fetches the current descriptor over a simple 32-bit memory master port and checks who owns it.

If the controller owns the descriptor, the frame bytes are packed into words and written into the buffer. Any bytes past the buffer size are dropped. The block then writes back the received byte count and the status, which releases ownership, and moves to the next ring slot. If the host still owns the descriptor, the whole frame is discarded and a missed-frame counter goes up.

The byte stream uses a valid/ready handshake. Start-of-frame and end-of-frame flags travel with the data, and three receive error flags are sampled on the last byte. The memory port holds a request until a one-cycle acknowledge. Read data is taken on that acknowledge.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the ring index and the missed-frame count are zero, no memory request is raised, and no stream byte is accepted while `rx_valid` is low.
- R2: A start-of-frame beat causes reads of the descriptor words at ring base + index*16 + 0 (buffer address) and + 4. In the word at +4, bit 31 is ownership (1 = controller may fill), bits 30:16 are the rest of status, and bits 15:0 are the buffer length.
- R3: Frame byte n is written to buffer address + n, in little-endian byte lanes of 32-bit word writes. Only the lanes holding frame bytes are enabled.
- R4: The buffer size is the two's-complement negation of the 16-bit buffer length. Bytes beyond that size are not written, and no memory beyond the kept bytes changes.
- R5: The word at descriptor + 8 is written with the total number of received bytes, CRC included, in bits 11:0 (saturating at 4095), and zeros above.
- R6: Status bits 15:8 (word +4, bits 31:24) are written as follows. Bit 15 = 0 hands the descriptor back. The other bits are 0x03 (start+end) OR framing 0x20, overflow 0x10 (frame longer than buffer), CRC 0x08, FIFO 0x04, plus 0x40 when any error flag is set. Only byte lanes 3:2 are written, so the buffer length is preserved.
- R7: The status write of a frame comes after its message-length write.
- R8: After each delivered frame the index advances by one and wraps from 2^`ring_log2`-1 to 0.
- R9: A frame whose descriptor has ownership bit 0 is consumed and discarded with no memory write. The missed count rises by one and the index does not change.
- R10: Stream beats arriving outside a frame (no start flag while idle) are accepted and discarded.
- R11: Once raised, a memory request holds its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0, 16-byte aligned |
| ring_log2 | input | LGW | log2 of the number of ring entries |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted when high with rx_valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 3 | {framing, CRC, FIFO} error flags, valid with rx_eof |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_ack | input | 1 | One-cycle completion of the request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| cur_idx | output | IDXW | Current ring index |
| missed_cnt | output | MISSW | Frames dropped on host-owned descriptors |

## Verification
A wrong byte lane or count in the packing path shows up as corrupt buffer bytes or a bad length word. A wrong truncation limit shows up as a changed guard byte right after the kept bytes, and all of these are visible once the frame's descriptor is written back. Errors in the ownership decision or in the index have an immediate effect: the frame lands in the wrong buffer, or the missed count moves when it should not. This is seen at the next frame's descriptor fetch address. A status written too early shows up within the same frame as a release before the length write.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW    = 32,
  parameter int IDXW  = 7,
  parameter int MISSW = 16,
  localparam int LGW  = $clog2(IDXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ring_base,
  input  logic [LGW-1:0]   ring_log2,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [2:0]       rx_err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [IDXW-1:0]  cur_idx,
  output logic [MISSW-1:0] missed_cnt
);

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_DATA, S_DROP, S_WDAT, S_WLEN, S_WST
  } st_t;

  st_t            st;
  logic [AW-1:0]  buf_base;
  logic [15:0]    buf_size;
  logic [15:0]    cnt;
  logic [13:0]    wword;
  logic [31:0]    wdat;
  logic [3:0]     wbe;
  logic           eof_seen;
  logic [2:0]     errs;
  logic           len_done;

  logic [AW-1:0]   desc_addr;
  logic [IDXW-1:0] idx_mask;
  logic            accept, keep, oflo, any_err;
  logic [1:0]      lane;
  logic [3:0]      nbe;
  logic [31:0]     ndat;
  logic [15:0]     cnt_inc;
  logic [11:0]     msglen;
  logic [7:0]      stat_hi;
  logic            unused_bits;

  assign desc_addr = ring_base + AW'({cur_idx, 4'b0000});
  assign idx_mask  = IDXW'((1 << ring_log2) - 1);
  assign unused_bits = ^mem_rdata[30:16];

  always_comb begin
    case (st)
      S_IDLE:         rx_ready = rx_valid && !rx_sof;
      S_DATA, S_DROP: rx_ready = 1'b1;
      default:        rx_ready = 1'b0;
    endcase
  end
  assign accept = rx_valid && rx_ready;

  assign keep    = cnt < buf_size;
  assign lane    = cnt[1:0];
  assign nbe     = wbe | (keep ? (4'b0001 << lane) : 4'b0000);
  assign ndat    = keep ? (wdat | (32'(rx_data) << {lane, 3'b000})) : wdat;
  assign cnt_inc = (cnt == 16'hFFFF) ? cnt : cnt + 16'd1;

  assign oflo    = cnt > buf_size;
  assign any_err = oflo || (|errs);
  assign msglen  = (cnt > 16'd4095) ? 12'hFFF : cnt[11:0];
  assign stat_hi = {1'b0, any_err, errs[2], oflo, errs[1], errs[0], 2'b11};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = 32'h0;
    mem_be    = 4'b0000;
    case (st)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
      end
      S_WDAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_base + AW'({wword, 2'b00});
        mem_wdata = wdat;
        mem_be    = wbe;
      end
      S_WLEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(8);
        mem_wdata = {20'h0, msglen};
        mem_be    = 4'b1111;
      end
      S_WST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(4);
        mem_wdata = {stat_hi, 24'h0};
        mem_be    = 4'b1100;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur_idx    <= '0;
      missed_cnt <= '0;
      buf_base   <= '0;
      buf_size   <= '0;
      cnt        <= '0;
      wword      <= '0;
      wdat       <= '0;
      wbe        <= '0;
      eof_seen   <= 1'b0;
      errs       <= '0;
      len_done   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (rx_valid && rx_sof) st <= S_RD0;
        S_RD0: if (mem_ack) begin
          buf_base <= mem_rdata[AW-1:0];
          st       <= S_RD1;
        end
        S_RD1: if (mem_ack) begin
          if (mem_rdata[31]) begin
            buf_size <= 16'h0 - mem_rdata[15:0];
            cnt      <= '0;
            wdat     <= '0;
            wbe      <= '0;
            eof_seen <= 1'b0;
            errs     <= '0;
            st       <= S_DATA;
          end else begin
            st <= S_DROP;
          end
        end
        S_DATA: if (accept) begin
          cnt  <= cnt_inc;
          wdat <= ndat;
          wbe  <= nbe;
          if (keep) wword <= cnt[15:2];
          if (rx_eof) begin
            eof_seen <= 1'b1;
            errs     <= rx_err;
          end
          if (((keep && lane == 2'd3) || rx_eof) && nbe != 4'b0000)
            st <= S_WDAT;
          else if (rx_eof)
            st <= S_WLEN;
        end
        S_DROP: if (accept && rx_eof) begin
          if (missed_cnt != {MISSW{1'b1}}) missed_cnt <= missed_cnt + 1'b1;
          st <= S_IDLE;
        end
        S_WDAT: if (mem_ack) begin
          wdat <= '0;
          wbe  <= '0;
          st   <= eof_seen ? S_WLEN : S_DATA;
        end
        S_WLEN: if (mem_ack) begin
          len_done <= 1'b1;
          st       <= S_WST;
        end
        S_WST: if (mem_ack) begin
          len_done <= 1'b0;
          cur_idx  <= (cur_idx + 1'b1) & idx_mask;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R9
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (missed_cnt == $past(missed_cnt) || missed_cnt == $past(missed_cnt) + 1'b1));

  // R6
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == desc_addr + AW'(4) |-> !mem_wdata[31] && mem_be == 4'b1100);

  // R7
  status_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == desc_addr + AW'(4) |-> len_done);

  // R3
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'b0000);

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx & ~idx_mask) == '0);

endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  localparam int CLK_P = 10;
  localparam int AW = 32, IDXW = 7, MISSW = 16, LGW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] ring_base = 32'h0;
  logic [LGW-1:0] ring_log2 = 3'd2;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic [2:0] rx_err = 0;
  logic rx_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [3:0] mem_be;
  logic mem_ack = 1'b0;
  logic [IDXW-1:0] cur_idx;
  logic [MISSW-1:0] missed_cnt;

  rx_ring_writer #(.AW(AW), .IDXW(IDXW), .MISSW(MISSW)) i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_err(rx_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cur_idx(cur_idx), .missed_cnt(missed_cnt));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done_rep = 0;
  logic [7:0] mem [0:16383];
  logic [7:0] fr [0:511];
  int hold_fail = 0, ord_fail = 0, wr_count = 0;
  logic [31:0] last_rd0 = 32'hFFFF_FFFF;
  bit lenw = 0;
  int e_idx = 0, e_miss = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_rep) begin
      done_rep = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    report();
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  // memory model with random acknowledge latency
  initial begin
    bit busy = 0;
    int lat = 0;
    logic [31:0] l_addr = 0;
    logic l_we = 0;
    forever begin
      @(posedge clk);
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (!busy) begin
          busy = 1; l_addr = mem_addr; l_we = mem_we; lat = $urandom % 3;
        end else if (mem_addr !== l_addr || mem_we !== l_we) hold_fail++;
        if (lat == 0) begin
          int a;
          a = int'(mem_addr[13:0]) & ~3;
          busy = 0;
          if (mem_we) begin
            wr_count++;
            for (int b = 0; b < 4; b++) if (mem_be[b]) mem[a+b] = mem_wdata[8*b +: 8];
            if (a < 64 && a[3:0] == 4'h8) lenw = 1;
            if (a < 64 && a[3:0] == 4'h4) begin
              if (!lenw) ord_fail++;
              lenw = 0;
            end
          end else begin
            if (a < 64 && a[3:0] == 4'h0) last_rd0 = 32'(a);
            mem_rdata <= rd32(a);
          end
          mem_ack <= 1'b1;
        end else lat--;
      end
    end
  end

  function automatic int bufa(input int i);
    return 32'h400 + i * 32'h400;
  endfunction

  function automatic logic [7:0] exp_hi(input int len, input int size, input logic [2:0] e);
    logic [7:0] h;
    h = 8'h03;
    if (e[2]) h |= 8'h20;
    if (len > size) h |= 8'h10;
    if (e[1]) h |= 8'h08;
    if (e[0]) h |= 8'h04;
    if (e != 0 || len > size) h |= 8'h40;
    return h;
  endfunction

  task automatic arm(input int i, input int size);
    logic [15:0] nl;
    int d;
    d = i * 16;
    nl = 16'h0 - 16'(size);
    {mem[d+3], mem[d+2], mem[d+1], mem[d]} = bufa(i);
    {mem[d+7], mem[d+6], mem[d+5], mem[d+4]} = {16'h8000, nl};
    {mem[d+11], mem[d+10], mem[d+9], mem[d+8]} = 32'h0;
    for (int k = 0; k < size + 8; k++) mem[bufa(i) + k] = 8'hEE;
  endtask

  task automatic beat(input logic [7:0] d, input logic s, input logic e, input logic [2:0] er);
    bit got = 0;
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_sof = s; rx_eof = e; rx_err = er;
    while (!got) begin
      #(CLK_P/4);
      if (rx_ready) got = 1;
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
  endtask

  task automatic frame(input int len, input int size, input logic [2:0] er, input bit own);
    int w0, kept, d, bb;
    logic [31:0] w;
    bit dok;
    if (own) arm(e_idx, size);
    for (int k = 0; k < len; k++) fr[k] = 8'($urandom);
    w0 = wr_count;
    last_rd0 = 32'hFFFF_FFFF;
    for (int k = 0; k < len; k++)
      beat(fr[k], k == 0, k == len - 1, (k == len - 1) ? er : 3'b000);
    repeat (40) @(posedge clk);
    @(negedge clk);
    d = e_idx * 16;
    chk(last_rd0 == 32'(d), "R2 descriptor fetch address", last_rd0, d);
    if (own) begin
      bb = bufa(e_idx);
      kept = (len < size) ? len : size;
      dok = 1;
      for (int k = 0; k < kept; k++) if (mem[bb+k] !== fr[k]) dok = 0;
      chk(dok, "R3 buffer bytes", dok, 1);
      chk(mem[bb+kept] == 8'hEE, "R4 byte past kept data untouched", mem[bb+kept], 8'hEE);
      w = rd32(d + 8);
      chk(w == 32'(len), "R5 message length", w, len);
      w = rd32(d + 4);
      chk(w[31:24] == exp_hi(len, size, er), "R6 status high byte", w[31:24], exp_hi(len, size, er));
      chk(w[15:0] == 16'h0 - 16'(size) && w[23:16] == 8'h0, "R6 length half preserved", w[23:0], {8'h0, 16'h0 - 16'(size)});
      chk(ord_fail == 0, "R7 status after length", ord_fail, 0);
      e_idx = (e_idx + 1) % 4;
    end else begin
      e_miss++;
      chk(wr_count == w0, "R9 no write on dropped frame", wr_count - w0, 0);
      chk(missed_cnt == MISSW'(e_miss), "R9 missed count", missed_cnt, e_miss);
    end
    chk(cur_idx == IDXW'(e_idx), "R8 ring index", cur_idx, e_idx);
    chk(hold_fail == 0, "R11 request held until ack", hold_fail, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16384; k++) mem[k] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_req == 1'b0, "R1 no request in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(cur_idx == 0 && missed_cnt == 0, "R1 reset index and count", {cur_idx, missed_cnt}, 0);
    chk(mem_req == 1'b0 && rx_ready == 1'b0, "R1 idle outputs", {mem_req, rx_ready}, 0);

    frame(64, 1536, 3'b000, 1);
    frame(20, 10, 3'b000, 1);
    frame(33, 100, 3'b111, 1);
    frame(9, 64, 3'b000, 0);
    // R10: stray beats with no start flag while idle
    for (int k = 0; k < 3; k++) beat(8'hA5, 1'b0, 1'b0, 3'b000);
    @(negedge clk);
    chk(mem_req == 1'b0 && missed_cnt == MISSW'(e_miss), "R10 stray beats discarded", {mem_req, missed_cnt}, e_miss);
    frame(7, 200, 3'b010, 1);
    chk(cur_idx == 0, "R8 wrap to zero", cur_idx, 0);
    frame(5, 0, 3'b000, 1);

    for (int n = 0; n < 24; n++) begin
      int len, size;
      logic [2:0] er;
      len = 1 + ($urandom % 300);
      size = $urandom % 257;
      er = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      frame(len, size, er, ($urandom % 8) != 0);
    end
    report();
  end
endmodule